// File: doc/BRIEF.md
# Page-Buffered Non-Volatile Write Controller

This block sits behind a serial register interface and in front of a byte-wide non-volatile store. A write transaction opens with a start address, carries any number of data bytes, and closes with a bus STOP. The bytes are gathered in a one-page buffer of four bytes. A page is aligned, so its first address has the two low bits at zero. Nothing reaches the store while the transaction is open. At STOP the collected bytes are committed together, and only the positions that were actually written are changed.

A commit that needs a non-volatile cycle raises `busy` for `WR_CYCLES` clocks, and the store takes the new bytes as `busy` falls. While `busy` is high, new starts and new bytes are refused: `reject` flags them so the bus side can NACK, and they leave no trace. Each byte carries an attribute that says whether its register has a volatile copy. With `wr_inhibit` set at STOP, bytes of such registers are written straight away and need no busy period. Bytes of registers that live only in non-volatile storage still take the full delay.

Top module: `nvpage_wr_ctrl`

## Requirements
- R1: After reset `busy` and `reject` are 0 and every array location reads 0.
- R2: A transaction's first byte goes to the page offset given by the two low bits of `start_addr`, and later bytes go to the next offsets, all inside the aligned 4-byte page chosen by the upper address bits.
- R3: When more than four bytes arrive in one transaction, the offset wraps from 3 to 0 and a later byte replaces the earlier byte buffered at the same offset.
- R4: No array location changes while a transaction is open. At commit only the offsets that received a byte are written, and every other location keeps its value.
- R5: A delayed commit drives `busy` to 1 in the cycle after the STOP edge and holds it for exactly `WR_CYCLES` cycles. The delayed bytes become readable in the cycle in which `busy` returns to 0, and reads during `busy` return the old contents.
- R6: A STOP with no buffered byte starts no cycle, leaves `busy` at 0 and changes nothing.
- R7: With `wr_inhibit` = 1 at STOP, bytes sent with `byte_vol` = 1 (register has a volatile copy) are readable in the cycle after the STOP edge. If all buffered bytes are of this kind, `busy` stays 0.
- R8: With `wr_inhibit` = 1, bytes sent with `byte_vol` = 0 (non-volatile only) still take the full `WR_CYCLES` delay. In a mixed page the volatile-backed bytes appear at once and the others appear when `busy` falls.
- R9: While `busy` = 1, `reject` is 1 in any cycle with `txn_start` or `byte_valid` high. A rejected start, byte or STOP has no effect on the array or on later commits.
- R10: With `wr_inhibit` = 0 every buffered byte takes the delayed path, whatever its `byte_vol`.
- R11: A byte presented with no open transaction is ignored. It does not raise `reject`, and a following STOP finds nothing to commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Opens a write transaction at `start_addr` |
| start_addr | input | ADDR_W | Register address of the first byte |
| byte_valid | input | 1 | A data byte is present this cycle |
| byte_data | input | 8 | Data byte |
| byte_vol | input | 1 | 1: target register has a volatile copy; 0: non-volatile only |
| txn_stop | input | 1 | Bus STOP, closes the transaction and triggers the commit |
| wr_inhibit | input | 1 | Skips the non-volatile cycle for volatile-backed bytes, sampled at STOP |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` (combinational) |
| busy | output | 1 | Non-volatile write cycle in progress |
| reject | output | 1 | Start or byte refused because a cycle is in progress |

## Verification
A wrong offset or a mask bit that is stuck shows up when the store is read back after `busy` falls: a byte lands at the wrong address, or a location that was never written changes. A busy counter that is off by one shows as a `busy` period of the wrong length, counted on the cycle after STOP. A mistake in the inhibit path shows one cycle after STOP, either as `busy` rising when it should not or as a volatile-backed byte that is still missing from the store. A buffer that was touched while busy shows in the values of the next commit.

// File: rtl/nvpw_pkg.sv
package nvpw_pkg;
    localparam int OFF_W  = 2;
    localparam int PAGE_N = 1 << OFF_W;

    typedef logic [7:0]              byte_t;
    typedef logic [PAGE_N-1:0]       lane_mask_t;
    typedef logic [PAGE_N-1:0][7:0]  page_data_t;
endpackage

// File: rtl/nvpw_page_buffer.sv
module nvpw_page_buffer
    import nvpw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      open_i,
    input  logic [ADDR_W-1:0]         open_addr_i,
    input  logic                      wr_i,
    input  byte_t                     wr_data_i,
    input  logic                      wr_vol_i,
    input  logic                      close_i,
    input  logic                      clr_i,
    output logic [ADDR_W-OFF_W-1:0]   base_o,
    output lane_mask_t                mask_o,
    output lane_mask_t                vol_o,
    output page_data_t                data_o
);
    localparam int BASE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              active;
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  off;
        lane_mask_t        mask;
        lane_mask_t        vol;
        page_data_t        data;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (open_i) begin
            s_d.active = 1'b1;
            s_d.base   = open_addr_i[ADDR_W-1:OFF_W];
            s_d.off    = open_addr_i[OFF_W-1:0];
            s_d.mask   = '0;
            s_d.vol    = '0;
        end else if (wr_i && s_q.active) begin
            s_d.data[s_q.off] = wr_data_i;
            s_d.vol[s_q.off]  = wr_vol_i;
            s_d.mask[s_q.off] = 1'b1;
            s_d.off           = s_q.off + 1'b1;
        end
        if (close_i) begin
            s_d.active = 1'b0;
        end
        if (clr_i) begin
            s_d.mask = '0;
            s_d.vol  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign base_o = s_q.base;
    assign mask_o = s_q.mask;
    assign vol_o  = s_q.vol;
    assign data_o = s_q.data;

    // R3: the in-page offset wraps from the last lane back to lane 0
    p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && s_q.active && !open_i && s_q.off == OFF_W'(PAGE_N-1)) |=> (s_q.off == '0));

    // R11: a byte outside an open transaction leaves the buffer untouched
    p_idle_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !s_q.active && !open_i && !clr_i) |=> $stable(s_q.mask));
endmodule

// File: rtl/nvpw_commit_seq.sv
module nvpw_commit_seq
    import nvpw_pkg::*;
#(
    parameter int WR_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch_i,
    input  lane_mask_t dly_mask_i,
    output logic       busy_o,
    output logic       done_o,
    output lane_mask_t pend_mask_o
);
    localparam int CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        lane_mask_t       pend;
    } seq_t;

    seq_t s_d, s_q;
    logic done;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.cnt == '0);
        if (s_q.busy) begin
            if (done) begin
                s_d.busy = 1'b0;
                s_d.pend = '0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (launch_i && (dly_mask_i != '0)) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(WR_CYCLES - 1);
            s_d.pend = dly_mask_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o      = s_q.busy;
    assign done_o      = done;
    assign pend_mask_o = s_q.pend;

    // R5: a launch with delayed lanes raises busy on the next cycle and keeps its lanes
    p_launch_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !s_q.busy && dly_mask_i != '0) |=> (s_q.busy && s_q.pend == $past(dly_mask_i)));

    // R5: busy cannot drop before the countdown reaches zero
    p_busy_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0) |=> s_q.busy);

    // R6: a launch with nothing to delay never starts a cycle
    p_no_empty_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && dly_mask_i == '0) |=> !s_q.busy);
endmodule

// File: rtl/nvpw_array.sv
module nvpw_array
    import nvpw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] wr_base_i,
    input  lane_mask_t              wr_mask_i,
    input  page_data_t              wr_data_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output byte_t                   rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
    } arr_t;

    arr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int ln = 0; ln < PAGE_N; ln++) begin
            if (wr_mask_i[ln]) begin
                s_d.mem[{wr_base_i, OFF_W'(ln)}] = wr_data_i[ln];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o = s_q.mem[rd_addr_i];

    // R4: with no lane enabled the array keeps every location
    p_masked_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask_i == '0) |=> $stable(s_q.mem));
endmodule

// File: rtl/nvpage_wr_ctrl.sv
module nvpage_wr_ctrl
    import nvpw_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int WR_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              byte_vol,
    input  logic              txn_stop,
    input  logic              wr_inhibit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              reject
);
    localparam int BASE_W = ADDR_W - OFF_W;

    logic              open_ok, wr_ok, close_ok, launch, done, clr;
    logic [BASE_W-1:0] buf_base;
    lane_mask_t        buf_mask, buf_vol, imm_mask, dly_mask, pend_mask, arr_mask;
    page_data_t        buf_data;

    always_comb begin
        open_ok  = txn_start  && !busy;
        wr_ok    = byte_valid && !busy;
        close_ok = txn_stop   && !busy;
        launch   = close_ok && (buf_mask != '0);
        imm_mask = buf_mask & buf_vol & {PAGE_N{wr_inhibit}};
        dly_mask = buf_mask & ~imm_mask;
        if (launch) begin
            arr_mask = imm_mask;
        end else if (done) begin
            arr_mask = pend_mask;
        end else begin
            arr_mask = '0;
        end
        clr    = (close_ok && dly_mask == '0) || done;
        reject = busy && (txn_start || byte_valid);
    end

    nvpw_page_buffer #(.ADDR_W(ADDR_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (open_ok),
        .open_addr_i (start_addr),
        .wr_i        (wr_ok),
        .wr_data_i   (byte_data),
        .wr_vol_i    (byte_vol),
        .close_i     (close_ok),
        .clr_i       (clr),
        .base_o      (buf_base),
        .mask_o      (buf_mask),
        .vol_o       (buf_vol),
        .data_o      (buf_data)
    );

    nvpw_commit_seq #(.WR_CYCLES(WR_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .dly_mask_i  (launch ? dly_mask : '0),
        .busy_o      (busy),
        .done_o      (done),
        .pend_mask_o (pend_mask)
    );

    nvpw_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_base_i (buf_base),
        .wr_mask_i (arr_mask),
        .wr_data_i (buf_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // R9: bytes offered while busy must not alter the held page
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(buf_mask) && $stable(buf_data));

    // R6: STOP with an empty buffer keeps busy low
    p_empty_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_stop && !busy && buf_mask == '0) |=> !busy);

    // R7: inhibit with only volatile-backed lanes needs no cycle
    p_inh_nodelay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_stop && !busy && wr_inhibit && (buf_mask & ~buf_vol) == '0) |=> !busy);

    // R5: the buffer is empty again once the cycle ends
    p_clear_after_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (buf_mask == '0));
endmodule

// File: tb/nvpage_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvpage_wr_ctrl_tb_top;
    localparam int AW = 4;
    localparam int WC = 5;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic txn_start = 0, byte_valid = 0, byte_vol = 0, txn_stop = 0, wr_inhibit = 0;
    logic [AW-1:0] start_addr = '0, rd_addr = '0;
    logic [7:0] byte_data = '0, rd_data;
    logic busy, reject;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [DEPTH];

    always #2.5 clk = ~clk;

    nvpage_wr_ctrl #(.ADDR_W(AW), .WR_CYCLES(WC)) dut_i (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_vol(byte_vol),
        .txn_stop(txn_stop), .wr_inhibit(wr_inhibit), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .reject(reject)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_array(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #0.1;
            check(rd_data === model[a], tag, int'(rd_data), int'(model[a]));
        end
    endtask

    // One transaction: n bytes from addr; lane attribute from volpat[lane]
    task automatic run_txn(input int addr, input int n, input logic inh,
                           input logic [3:0] volpat, input int seed, input string tag);
        logic [7:0] bd [4];
        logic [3:0] bm, imm, dly;
        int cyc;
        bm = '0;
        @(negedge clk);
        txn_start = 1; start_addr = AW'(addr);
        @(negedge clk);
        txn_start = 0;
        for (int i = 0; i < n; i++) begin
            int pos;
            pos = (addr + i) % 4;
            byte_valid = 1;
            byte_data  = 8'((seed * 37 + i * 11 + addr * 5 + 1) & 8'hFF);
            byte_vol   = volpat[pos];
            bd[pos] = byte_data;
            bm[pos] = 1'b1;
            @(negedge clk);
        end
        byte_valid = 0;
        wr_inhibit = inh;
        txn_stop = 1;
        check_array({tag, " R4 open"});
        @(negedge clk);
        txn_stop = 0;
        imm = bm & volpat & {4{inh}};
        dly = bm & ~imm;
        for (int l = 0; l < 4; l++)
            if (imm[l]) model[(addr & ~3) + l] = bd[l];
        check(busy === (dly != 0), {tag, " R5/R6/R7 busy after stop"}, int'(busy), int'(dly != 0));
        check_array({tag, " R7/R8 early contents"});
        cyc = 0;
        while (busy === 1'b1 && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        check(cyc == ((dly != 0) ? WC : 0), {tag, " R5/R8 busy length"}, cyc, (dly != 0) ? WC : 0);
        for (int l = 0; l < 4; l++)
            if (dly[l]) model[(addr & ~3) + l] = bd[l];
        check_array({tag, " R2/R3/R4 final contents"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        check(reject === 1'b0, "R1 reject", int'(reject), 0);
        check_array("R1 array zero");

        // R2 R3 R4 R6 R10: every offset, 0..6 bytes, inhibit off
        for (int off = 0; off < 4; off++)
            for (int n = 0; n <= 6; n++)
                run_txn(((off + n) % 4) * 4 + off, n, 1'b0, 4'((off * 5 + n) & 15),
                        off * 7 + n, "R10 sweep");

        // R7 R8: inhibit on, every attribute pattern over a full page
        for (int vp = 0; vp < 16; vp++)
            run_txn((vp % 4) * 4 + (vp % 4), 4, 1'b1, 4'(vp), 50 + vp, "R7/R8 inhibit");

        // R9: requests while busy are rejected and ignored
        fork
            run_txn(8, 2, 1'b0, 4'hF, 99, "R9 base");
            begin
                repeat (5) @(negedge clk);
                #0.5;
                txn_start = 1; start_addr = 4'd12;
                #0.1;
                check(reject === 1'b1, "R9 reject start", int'(reject), 1);
                @(negedge clk); #0.5;
                txn_start = 0; byte_valid = 1; byte_data = 8'hEE; byte_vol = 1;
                #0.1;
                check(reject === 1'b1, "R9 reject byte", int'(reject), 1);
                @(negedge clk); #0.5;
                byte_valid = 0; txn_stop = 1;
                @(negedge clk); #0.5;
                txn_stop = 0;
            end
        join
        @(negedge clk);
        txn_stop = 1;
        @(negedge clk);
        txn_stop = 0;
        check(busy === 1'b0, "R9 rejected bytes left nothing", int'(busy), 0);
        check_array("R9 array after rejected traffic");

        // R11: byte with no open transaction
        @(negedge clk);
        byte_valid = 1; byte_data = 8'h5A; byte_vol = 0;
        #0.1;
        check(reject === 1'b0, "R11 no reject when idle", int'(reject), 0);
        @(negedge clk);
        byte_valid = 0; txn_stop = 1;
        @(negedge clk);
        txn_stop = 0;
        check(busy === 1'b0, "R11 stray byte no cycle", int'(busy), 0);
        check_array("R11 array unchanged");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule